// File: doc/BRIEF.md
# Refresh Row Counter and Counter-Test Cycle Decoder

This block is the memory-side control logic of a page-mode DRAM. It watches the active-low row strobe, column strobe, write strobe and output-enable pins and an 11-bit multiplexed address bus. All of these are sampled on a fast system clock. From the order of strobe edges it works out what kind of cycle the controller is running and drives internal enables toward a behavioural cell array: a row refresh, a read, a write or a read-modify-write. With each enable it supplies the row and column addresses.

A column strobe that falls while the row strobe is still high, followed by a falling row strobe, is a refresh with the column strobe first. That refresh takes its row from an internal 11-bit counter, and the counter steps when the cycle ends. If the column strobe then goes high and falls again while the row strobe is held low, the block enters the counter-test cycle. The row still comes from the counter, the column is taken from the pins on that second falling edge, and reads, writes and read-modify-writes are all allowed. Ordinary accesses (row strobe first) take the row from the pins. A run of eight row-only cycles clears the counter to a known start point.

Every pin change shows on the outputs two clock cycles later: one cycle for the input sampling register and one for the output register.

Top module: `dram_cbr_ctrl`

## Requirements
- R1: After reset, and after a reset applied in the middle of a cycle, rd_en, wr_en, dq_oe and rfsh_en are low, row_addr and col_addr are 0, and the next refresh uses row 0.
- R2: A column strobe that falls while the row strobe is high, followed by a falling row strobe, gives a one-cycle rfsh_en pulse two clocks after the row strobe falls, with row_addr equal to the counter value.
- R3: The refresh counter advances by one when the row strobe rises to end a column-first refresh (plain or test cycle), and it wraps from 2047 to 0.
- R4: After a column-first refresh, if the column strobe goes high and then falls while the row strobe stays low, an access starts with row_addr equal to the counter value and col_addr equal to the address pins at that second falling edge.
- R5: If the write strobe is high when the column strobe falls in an access, rd_en is held high for as long as the column strobe stays low.
- R6: If the write strobe is already low when the column strobe falls (early write), wr_en pulses for exactly one cycle and rd_en stays low.
- R7: In a read access, a falling write strobe gives a one-cycle wr_en pulse while rd_en stays high (read-modify-write).
- R8: dq_oe is high only during a read access while the output-enable pin is low; it is low whenever the output-enable or column strobe is high.
- R9: Eight consecutive row-only cycles (the row strobe falls and rises while the column strobe stays high) clear the counter to 0. Any other cycle in between restarts that count.
- R10: In an ordinary access, row_addr takes the address pins when the row strobe falls with the column strobe high, and col_addr takes them when the column strobe then falls.
- R11: A rising row strobe ends any cycle: the enables drop, and after an ordinary access or a row-only cycle short of the eighth, the counter is unchanged.
- R12: If the column strobe rises again before the row strobe falls, no refresh takes place and the counter is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed row/column address pins |
| rd_en | output | 1 | Array read enable, level |
| wr_en | output | 1 | Array write strobe, one-cycle pulse |
| dq_oe | output | 1 | Data output driver enable |
| rfsh_en | output | 1 | Row refresh strobe, one-cycle pulse |
| row_addr | output | 11 | Row address to the array |
| col_addr | output | 11 | Column address to the array |

## Verification
The assertions watch properties that hold on every cycle. The refresh and write strobes are single-cycle pulses. The output driver needs both a read enable and, one cycle earlier, a sampled low output-enable and column strobe. A read enable needs a low row strobe on the cycle before. The counter moves only at a cycle end, and only by one when it steps. Refresh and access enables never overlap. Only the bench's scenarios can show the addressing and cycle-classification results: which row a refresh or test cycle uses across a sequence of cycles, the wrap at 2047, clearing after eight row-only cycles but not after seven or after an interrupted run, abandoned column-first starts, and recovery from a reset applied in the middle of a cycle.

// File: rtl/dram_cbr_pkg.sv
package dram_cbr_pkg;

  // Cycle decoder states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CBR_ARM,   // column strobe low, row strobe still high
    ST_CBR_REF,   // refresh running from the counter
    ST_CBR_GAP,   // column strobe back high, row strobe held low
    ST_TEST,      // counter-test access
    ST_ROW_OPEN,  // row strobe low, row from pins
    ST_ACCESS     // ordinary column access
  } cyc_state_t;

  // Strobe positions in the sampled vector
  localparam int STB_RAS = 0;
  localparam int STB_CAS = 1;
  localparam int STB_WE  = 2;
  localparam int STB_OE  = 3;
  localparam int STB_N   = 4;
  // Strobes that need a falling-edge event (ras, cas, we)
  localparam int FALL_N  = 3;
  // Strobes that need a rising-edge event (ras, cas)
  localparam int RISE_N  = 2;

endpackage

// File: rtl/dram_cbr_sampler.sv
module dram_cbr_sampler
  import dram_cbr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STB_N-1:0]  stb_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [STB_N-1:0]  lvl_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [FALL_N-1:0] fall,
  output logic [RISE_N-1:0] rise
);

  // First sampling stage: strobes idle high after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_n  <= '1;
      addr_q <= '0;
    end else begin
      lvl_n  <= stb_n;
      addr_q <= addr;
    end
  end

  // One history flop per edge-detected strobe
  for (genvar g = 0; g < FALL_N; g++) begin : g_edge
    logic prev_q;

    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= lvl_n[g];
    end

    assign fall[g] = prev_q & ~lvl_n[g];

    if (g < RISE_N) begin : g_rise
      assign rise[g] = ~prev_q & lvl_n[g];
    end
  end

endmodule

// File: rtl/dram_cbr_row_counter.sv
module dram_cbr_row_counter #(
  parameter int ROW_W       = 11,
  parameter int INIT_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cbr_done,       // column-first refresh ended
  input  logic             ras_only_done,  // row-only cycle ended
  input  logic             other_done,     // ordinary access ended
  output logic [ROW_W-1:0] row_cnt
);

  localparam int STREAK_W = $clog2(INIT_CYCLES + 1);
  localparam logic [STREAK_W-1:0] STREAK_LAST = STREAK_W'(INIT_CYCLES - 1);

  logic [STREAK_W-1:0] streak_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_cnt  <= '0;
      streak_q <= '0;
    end else if (cbr_done) begin
      row_cnt  <= row_cnt + 1'b1;   // natural wrap at 2**ROW_W
      streak_q <= '0;
    end else if (ras_only_done) begin
      if (streak_q == STREAK_LAST) begin
        row_cnt  <= '0;
        streak_q <= '0;
      end else begin
        streak_q <= streak_q + 1'b1;
      end
    end else if (other_done) begin
      streak_q <= '0;
    end
  end

  // R3: a completed column-first refresh moves the counter by exactly one
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
    cbr_done |=> row_cnt == $past(row_cnt) + 1'b1);

  // R11: without a refresh end or a row-only end the counter holds
  a_r11_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!cbr_done && !ras_only_done) |=> $stable(row_cnt));

  // R9: a row-only end either steps nothing or lands on zero
  a_r9_init_target: assert property (@(posedge clk) disable iff (rst)
    (ras_only_done && !cbr_done) |=> (row_cnt == $past(row_cnt) || row_cnt == '0));

endmodule

// File: rtl/dram_cbr_cycle_fsm.sv
module dram_cbr_cycle_fsm
  import dram_cbr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_ras_n,
  input  logic              s_cas_n,
  input  logic              s_we_n,
  input  logic              s_oe_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              cas_fall,
  input  logic              cas_rise,
  input  logic              we_fall,
  input  logic [ADDR_W-1:0] row_cnt,
  output logic              cbr_done,
  output logic              ras_only_done,
  output logic              other_done,
  output logic              rd_en,
  output logic              wr_en,
  output logic              dq_oe,
  output logic              rfsh_en,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr
);

  cyc_state_t        state_q, state_d;
  logic              rd_cyc_q, rd_cyc_d;    // write strobe high at column fall
  logic              acc_seen_q, acc_seen_d; // column access inside this row cycle
  logic              wr_pulse, rfsh_pulse;
  logic [ADDR_W-1:0] row_d, col_d;

  function automatic logic in_access(cyc_state_t s);
    return (s == ST_ACCESS) || (s == ST_TEST);
  endfunction

  always_comb begin
    state_d       = state_q;
    rd_cyc_d      = rd_cyc_q;
    acc_seen_d    = acc_seen_q;
    row_d         = row_addr;
    col_d         = col_addr;
    wr_pulse      = 1'b0;
    rfsh_pulse    = 1'b0;
    cbr_done      = 1'b0;
    ras_only_done = 1'b0;
    other_done    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (ras_fall) begin
          if (!s_cas_n) begin
            state_d    = ST_CBR_REF;
            rfsh_pulse = 1'b1;
            row_d      = row_cnt;
          end else begin
            state_d    = ST_ROW_OPEN;
            row_d      = s_addr;
            acc_seen_d = 1'b0;
          end
        end else if (cas_fall && s_ras_n) begin
          state_d = ST_CBR_ARM;
        end
      end

      ST_CBR_ARM: begin
        if (ras_fall) begin
          state_d    = ST_CBR_REF;
          rfsh_pulse = 1'b1;
          row_d      = row_cnt;
        end else if (cas_rise) begin
          state_d = ST_IDLE;  // abandoned before the row strobe fell
        end
      end

      ST_CBR_REF: begin
        if (ras_rise) begin
          state_d  = ST_IDLE;
          cbr_done = 1'b1;
        end else if (cas_rise) begin
          state_d = ST_CBR_GAP;
        end
      end

      ST_CBR_GAP: begin
        if (ras_rise) begin
          state_d  = ST_IDLE;
          cbr_done = 1'b1;
        end else if (cas_fall) begin
          state_d  = ST_TEST;
          col_d    = s_addr;
          rd_cyc_d = s_we_n;
          wr_pulse = !s_we_n;
        end
      end

      ST_TEST: begin
        if (ras_rise) begin
          state_d  = ST_IDLE;
          cbr_done = 1'b1;
        end else if (cas_rise) begin
          state_d = ST_CBR_GAP;
        end else if (we_fall && rd_cyc_q) begin
          wr_pulse = 1'b1;
        end
      end

      ST_ROW_OPEN: begin
        if (ras_rise) begin
          state_d = ST_IDLE;
          if (acc_seen_q) other_done    = 1'b1;
          else            ras_only_done = 1'b1;
        end else if (cas_fall) begin
          state_d    = ST_ACCESS;
          col_d      = s_addr;
          rd_cyc_d   = s_we_n;
          wr_pulse   = !s_we_n;
          acc_seen_d = 1'b1;
        end
      end

      ST_ACCESS: begin
        if (ras_rise) begin
          state_d    = ST_IDLE;
          other_done = 1'b1;
        end else if (cas_rise) begin
          state_d = ST_ROW_OPEN;
        end else if (we_fall && rd_cyc_q) begin
          wr_pulse = 1'b1;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rd_cyc_q   <= 1'b0;
      acc_seen_q <= 1'b0;
      rd_en      <= 1'b0;
      wr_en      <= 1'b0;
      dq_oe      <= 1'b0;
      rfsh_en    <= 1'b0;
      row_addr   <= '0;
      col_addr   <= '0;
    end else begin
      state_q    <= state_d;
      rd_cyc_q   <= rd_cyc_d;
      acc_seen_q <= acc_seen_d;
      rd_en      <= in_access(state_d) && rd_cyc_d;
      wr_en      <= wr_pulse;
      dq_oe      <= in_access(state_d) && rd_cyc_d && !s_oe_n;
      rfsh_en    <= rfsh_pulse;
      row_addr   <= row_d;
      col_addr   <= col_d;
    end
  end

  // R2: refresh strobe is a single-cycle pulse
  a_r2_rfsh_single: assert property (@(posedge clk) disable iff (rst)
    rfsh_en |=> !rfsh_en);

  // R2: refresh only after both strobes were seen low
  a_r2_rfsh_strobes_low: assert property (@(posedge clk) disable iff (rst)
    rfsh_en |-> $past(!s_ras_n && !s_cas_n));

  // R6: write strobe toward the array is a single-cycle pulse
  a_r6_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R8: output driver only with a read, a low output enable and a low column strobe
  a_r8_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> rd_en);
  a_r8_oe_pins_low: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!s_oe_n && !s_cas_n));

  // R11: no read enable once the row strobe was seen high
  a_r11_read_needs_row: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> $past(!s_ras_n));

  // R5: refresh and access enables never overlap
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(rfsh_en && (rd_en || wr_en)));

endmodule

// File: rtl/dram_cbr_ctrl.sv
module dram_cbr_ctrl
  import dram_cbr_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int INIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic              dq_oe,
  output logic              rfsh_en,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr
);

  logic [STB_N-1:0]  stb_n, lvl_n;
  logic [ADDR_W-1:0] addr_q, row_cnt;
  logic [FALL_N-1:0] fall;
  logic [RISE_N-1:0] rise;
  logic              cbr_done, ras_only_done, other_done;

  always_comb begin
    stb_n          = '1;
    stb_n[STB_RAS] = ras_n;
    stb_n[STB_CAS] = cas_n;
    stb_n[STB_WE]  = we_n;
    stb_n[STB_OE]  = oe_n;
  end

  dram_cbr_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk    (clk),
    .rst    (rst),
    .stb_n  (stb_n),
    .addr   (addr),
    .lvl_n  (lvl_n),
    .addr_q (addr_q),
    .fall   (fall),
    .rise   (rise)
  );

  dram_cbr_row_counter #(.ROW_W(ADDR_W), .INIT_CYCLES(INIT_CYCLES)) u_counter (
    .clk           (clk),
    .rst           (rst),
    .cbr_done      (cbr_done),
    .ras_only_done (ras_only_done),
    .other_done    (other_done),
    .row_cnt       (row_cnt)
  );

  dram_cbr_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .s_ras_n       (lvl_n[STB_RAS]),
    .s_cas_n       (lvl_n[STB_CAS]),
    .s_we_n        (lvl_n[STB_WE]),
    .s_oe_n        (lvl_n[STB_OE]),
    .s_addr        (addr_q),
    .ras_fall      (fall[STB_RAS]),
    .ras_rise      (rise[STB_RAS]),
    .cas_fall      (fall[STB_CAS]),
    .cas_rise      (rise[STB_CAS]),
    .we_fall       (fall[STB_WE]),
    .row_cnt       (row_cnt),
    .cbr_done      (cbr_done),
    .ras_only_done (ras_only_done),
    .other_done    (other_done),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .dq_oe         (dq_oe),
    .rfsh_en       (rfsh_en),
    .row_addr      (row_addr),
    .col_addr      (col_addr)
  );

endmodule

// File: tb/dram_cbr_ctrl_tb.sv
`timescale 1ns/1ps
module dram_cbr_ctrl_tb;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          rd_en, wr_en, dq_oe, rfsh_en;
  logic [AW-1:0] row_addr, col_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dram_cbr_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .dq_oe(dq_oe), .rfsh_en(rfsh_en),
    .row_addr(row_addr), .col_addr(col_addr)
  );

  // Stimulus and expected outputs, two clocks after each drive
  typedef struct packed {
    logic          r, c, w, o;
    logic [AW-1:0] a;
    logic          rd, wr, oe, rf;
    logic          chk;
    logic [AW-1:0] row, col;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1,1,1,1,11'h000, 0,0,0,0, 1,11'h000,11'h000},  // idle
    '{1,0,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},  // column first
    '{0,0,1,1,11'h000, 0,0,0,1, 1,11'h000,11'h000},  // refresh row 0
    '{1,0,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{1,1,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{1,0,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{0,0,1,1,11'h000, 0,0,0,1, 1,11'h001,11'h000},  // refresh row 1
    '{0,1,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},  // gap
    '{0,0,1,1,11'h155, 1,0,0,0, 1,11'h001,11'h155},  // test read
    '{0,0,1,0,11'h155, 1,0,1,0, 0,11'h000,11'h000},  // output enabled
    '{0,0,1,1,11'h155, 1,0,0,0, 0,11'h000,11'h000},  // output off
    '{0,0,0,1,11'h155, 1,1,0,0, 1,11'h001,11'h155},  // rmw write
    '{0,1,0,1,11'h155, 0,0,0,0, 0,11'h000,11'h000},
    '{0,0,0,1,11'h2AA, 0,1,0,0, 1,11'h001,11'h2AA},  // early write
    '{0,0,0,1,11'h2AA, 0,0,0,0, 0,11'h000,11'h000},
    '{1,0,0,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},  // end, counter 2
    '{1,1,1,1,11'h000, 0,0,0,0, 1,11'h001,11'h2AA},
    '{0,1,1,1,11'h123, 0,0,0,0, 1,11'h123,11'h2AA},  // ordinary row
    '{0,0,1,0,11'h045, 1,0,1,0, 1,11'h123,11'h045},  // ordinary read
    '{0,1,1,0,11'h045, 0,0,0,0, 0,11'h000,11'h000},  // column high
    '{1,1,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{1,0,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{0,0,1,1,11'h000, 0,0,0,1, 1,11'h002,11'h045},  // refresh row 2
    '{1,0,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{1,1,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{1,0,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},  // abandoned start
    '{1,1,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{1,0,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{0,0,1,1,11'h000, 0,0,0,1, 1,11'h003,11'h045},  // refresh row 3
    '{1,0,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000},
    '{1,1,1,1,11'h000, 0,0,0,0, 0,11'h000,11'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, then wait until the outputs have settled
  task automatic drive(input logic r, input logic c, input logic w, input logic o,
                       input logic [AW-1:0] a);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
    repeat (2) @(negedge clk);
  endtask

  task automatic cbr(output logic [AW-1:0] row_seen, output logic rf_seen);
    drive(1, 0, 1, 1, '0);
    drive(0, 0, 1, 1, '0);
    row_seen = row_addr;
    rf_seen  = rfsh_en;
    drive(1, 0, 1, 1, '0);
    drive(1, 1, 1, 1, '0);
  endtask

  task automatic ras_only(input int n);
    for (int k = 0; k < n; k++) begin
      drive(0, 1, 1, 1, 11'h7FF);
      drive(1, 1, 1, 1, '0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] rs;
    logic          rf;
    int            bad;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 enables after reset", {rd_en, wr_en, dq_oe, rfsh_en}, 4'b0000);
    chk("R1 addresses after reset", {row_addr, col_addr}, '0);

    // Vector table: R2, R3, R4, R5, R6, R7, R8, R10, R11, R12
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].r, VEC[i].c, VEC[i].w, VEC[i].o, VEC[i].a);
      n_tests++;
      if ({rd_en, wr_en, dq_oe, rfsh_en} !== {VEC[i].rd, VEC[i].wr, VEC[i].oe, VEC[i].rf}) begin
        n_fail++;
        $display("FAIL R2,R4,R5,R6,R7,R8,R10,R12 row %0d enables: actual=%b expected=%b", i,
                 {rd_en, wr_en, dq_oe, rfsh_en}, {VEC[i].rd, VEC[i].wr, VEC[i].oe, VEC[i].rf});
      end
      if (VEC[i].chk) begin
        n_tests++;
        if ({row_addr, col_addr} !== {VEC[i].row, VEC[i].col}) begin
          n_fail++;
          $display("FAIL R3,R4,R10,R11,R12 row %0d addr: actual=%h/%h expected=%h/%h", i,
                   row_addr, col_addr, VEC[i].row, VEC[i].col);
        end
      end
    end

    // R9: seven row-only cycles do not clear (counter is 4)
    ras_only(7);
    cbr(rs, rf);
    chk("R9 seven row-only cycles keep counter", {rf, rs}, {1'b1, 11'd4});
    // R9: a refresh in between restarts the run
    ras_only(1);
    cbr(rs, rf);
    chk("R9 interrupted run does not clear", {rf, rs}, {1'b1, 11'd5});
    // R9: eight in a row clear
    ras_only(8);
    cbr(rs, rf);
    chk("R9 eight row-only cycles clear", {rf, rs}, {1'b1, 11'd0});

    // R3: every row in order, then the wrap
    bad = 0;
    for (int i = 1; i < 2047; i++) begin
      cbr(rs, rf);
      if (!rf || rs !== AW'(i)) bad++;
    end
    chk("R3 sequential refresh rows", bad, 0);
    cbr(rs, rf);
    chk("R3 last row", {rf, rs}, {1'b1, 11'd2047});
    cbr(rs, rf);
    chk("R3 wrap to zero", {rf, rs}, {1'b1, 11'd0});

    // R1: reset in the middle of a counter-test read (counter is 1)
    drive(1, 0, 1, 1, '0);
    drive(0, 0, 1, 1, '0);
    drive(0, 1, 1, 1, '0);
    drive(0, 0, 1, 1, 11'h0F0);
    chk("R4 test access before reset", {rd_en, row_addr, col_addr}, {1'b1, 11'd1, 11'h0F0});
    rst = 1'b1;
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 enables after mid-cycle reset", {rd_en, wr_en, dq_oe, rfsh_en}, 4'b0000);
    chk("R1 addresses after mid-cycle reset", {row_addr, col_addr}, '0);
    cbr(rs, rf);
    chk("R1 counter cleared by reset", {rf, rs}, {1'b1, 11'd0});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule